// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept or dropped. The decision uses only the frame's 48-bit destination address. The receive path presents the address once per frame on `da` with a one-cycle `da_valid` strobe. A fixed number of cycles later, the block raises `filt_done` for one cycle, and `filt_accept` gives the verdict.

Software or a control block sets up the filter through a simple word write port. That port holds the mode bits, a table of hash bits used for multicast, and a small set of exact unicast addresses.

The hash index for a multicast address is found as follows:

1. Compute a reflected CRC-32 over the six address bytes. This step runs serially, one byte per clock.
2. Invert the result.
3. Bit-reverse it.
4. Take its top `HASH_BITS` bits as the index.

The index selects one bit of the programmed hash table.

Top module: `daf_rx_addr_filter`

## Requirements
- R1: A strobe accepted while idle produces exactly one `filt_done` pulse. The pulse is visible after the 7th rising edge that follows the edge sampling the strobe, and `filt_accept` holds the verdict while `filt_done` is high. After reset, `filt_done` and `filt_accept` are 0.
- R2: With mode bit 0 (promiscuous) or mode bit 4 (receive-all) set, every frame is accepted, whatever the other mode bits, hash table and unicast entries hold.
- R3: A broadcast address (all 48 bits one) is accepted when mode bit 3 (broadcast block) is clear and rejected when it is set. R2 overrides this rule.
- R4: `da[7:0]` is the first address byte on the wire. An address is multicast when `da[0]` is 1. With mode bit 1 (pass-all-multicast) set, every non-broadcast multicast frame is accepted, regardless of the hash table.
- R5: With mode bit 2 (hash enable) set and mode bit 1 clear, a non-broadcast multicast frame is accepted exactly when hash table bit `idx` is 1. The index `idx` is computed as follows:
  - Take the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, bytes `da[7:0]` first, each byte least significant bit first) over the 6 bytes.
  - Invert it and bit-reverse it.
  - `idx` is the top `HASH_BITS` bits of that value.
  - Hash word w sits at write offset 0x10+w and holds table bits 32w..32w+31, so the index MSBs pick the word and its low 5 bits pick the bit.
- R6: With mode bits 1 and 2 both clear, non-broadcast multicast frames are rejected.
- R7: A unicast frame (`da[0]`=0, not R2) is accepted exactly when it equals all 48 bits of an enabled unicast entry. Entry e is written in two words:
  - low word at offset 0x40+2e holds `da[31:0]`;
  - high word at 0x41+2e holds `da[47:32]` in bits 15:0 and the enable in bit 31.
  - Entries reset disabled.
- R8: A `da_valid` strobe that arrives while a decision is in progress is ignored. The pending verdict is unchanged and no extra `filt_done` follows.
- R9: The mode register sits at offset 0x00, bits 4:0, and resets to 0. Writes take effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| filt_done | output | 1 | One-cycle verdict strobe |
| filt_accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
Each of the following is presented in several mode settings:
- unicast addresses that equal an enabled entry, differ by one bit from it, or equal a disabled entry;
- the broadcast address;
- multicast addresses.

Multicast addresses are chosen by searching for ones whose computed hash index lands in the low and in the high hash word. A second address with a different index then shows that only the programmed bit lets a frame through. Promiscuous and receive-all runs separate the override from the per-class rules. A strobe held over the busy window shows that only the first address is decided.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int DA_BYTES      = 6;
    localparam int OFS_MODE      = 'h00;
    localparam int OFS_HASH_BASE = 'h10;
    localparam int OFS_UC_BASE   = 'h40;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // Mode register fields, bit 0 is promisc
    typedef struct packed {
        logic rx_all;
        logic bcast_dis;
        logic hash_en;
        logic pass_mc;
        logic promisc;
    } daf_mode_t;

    typedef struct packed {
        logic        en;
        logic [47:0] mac;
    } uc_entry_t;

    // One byte through the reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  b);
        logic [31:0] c;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[k]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_regs.sv
module daf_regs
    import daf_pkg::*;
#(
    parameter int HASH_BITS  = 6,
    parameter int UC_ENTRIES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [7:0]                    wr_addr,
    input  logic [31:0]                   wr_data,
    output daf_mode_t                     mode_o,
    output logic [(1<<HASH_BITS)-1:0]     hash_tbl_o,
    output uc_entry_t [UC_ENTRIES-1:0]    uc_o
);
    localparam int NUM_HW = (1 << HASH_BITS) / 32;

    daf_mode_t   mode_q;
    logic [31:0] hw_q  [NUM_HW];
    logic [31:0] ulo_q [UC_ENTRIES];
    logic [16:0] uhi_q [UC_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            for (int w = 0; w < NUM_HW; w++) hw_q[w] <= '0;
            for (int e = 0; e < UC_ENTRIES; e++) begin
                ulo_q[e] <= '0;
                uhi_q[e] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == 8'(OFS_MODE)) mode_q <= daf_mode_t'(wr_data[4:0]);
            for (int w = 0; w < NUM_HW; w++)
                if (wr_addr == 8'(OFS_HASH_BASE + w)) hw_q[w] <= wr_data;
            for (int e = 0; e < UC_ENTRIES; e++) begin
                if (wr_addr == 8'(OFS_UC_BASE + 2*e))     ulo_q[e] <= wr_data;
                if (wr_addr == 8'(OFS_UC_BASE + 2*e + 1)) uhi_q[e] <= {wr_data[31], wr_data[15:0]};
            end
        end
    end

    assign mode_o = mode_q;

    for (genvar w = 0; w < NUM_HW; w++) begin : g_hash
        assign hash_tbl_o[w*32 +: 32] = hw_q[w];
    end

    for (genvar e = 0; e < UC_ENTRIES; e++) begin : g_uc
        assign uc_o[e].en  = uhi_q[e][16];
        assign uc_o[e].mac = {uhi_q[e][15:0], ulo_q[e]};
    end

endmodule

// File: rtl/daf_hash.sv
module daf_hash
    import daf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [47:0]          da_i,
    output logic                 rdy_o,
    output logic [HASH_BITS-1:0] idx_o
);
    localparam int CW = $clog2(DA_BYTES);

    logic [31:0] crc_q;
    logic [47:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic        run_q;
    logic        rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '1;
            sh_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= 1'b0;
            if (start_i && !run_q) begin
                crc_q <= '1;
                sh_q  <= da_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                crc_q <= crc_step_byte(crc_q, sh_q[7:0]);
                sh_q  <= sh_q >> 8;
                if (cnt_q == CW'(DA_BYTES - 1)) begin
                    run_q <= 1'b0;
                    rdy_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Inverted, bit-reversed CRC: its MSB is the inverse of crc bit 0
    for (genvar j = 0; j < HASH_BITS; j++) begin : g_idx
        assign idx_o[HASH_BITS-1-j] = ~crc_q[j];
    end

    assign rdy_o = rdy_q;

    a_r1_rdy_single: assert property (@(posedge clk) disable iff (rst)
        rdy_q |=> !rdy_q);

    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        run_q |-> !start_i);

endmodule

// File: rtl/daf_ucmatch.sv
module daf_ucmatch
    import daf_pkg::*;
#(
    parameter int UC_ENTRIES = 4
) (
    input  uc_entry_t [UC_ENTRIES-1:0] uc_i,
    input  logic [47:0]                da_i,
    output logic                       hit_o
);
    logic [UC_ENTRIES-1:0] hits;

    for (genvar e = 0; e < UC_ENTRIES; e++) begin : g_cmp
        assign hits[e] = uc_i[e].en && (uc_i[e].mac == da_i);
    end

    assign hit_o = |hits;

endmodule

// File: rtl/daf_rx_addr_filter.sv
module daf_rx_addr_filter
    import daf_pkg::*;
#(
    parameter int HASH_BITS  = 6,
    parameter int UC_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        da_valid,
    input  logic [47:0] da,
    output logic        filt_done,
    output logic        filt_accept
);
    daf_mode_t                    mode;
    logic [(1<<HASH_BITS)-1:0]    hash_tbl;
    uc_entry_t [UC_ENTRIES-1:0]   uc_tbl;
    logic                         start;
    logic                         hash_rdy;
    logic [HASH_BITS-1:0]         hash_idx;
    logic                         uc_hit;
    logic                         busy_q;
    logic [47:0]                  da_q;
    logic                         done_q;
    logic                         acc_q;
    logic                         is_bc;
    logic                         is_mc;
    logic                         verdict;

    daf_regs #(.HASH_BITS(HASH_BITS), .UC_ENTRIES(UC_ENTRIES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .mode_o(mode), .hash_tbl_o(hash_tbl), .uc_o(uc_tbl)
    );

    daf_hash #(.HASH_BITS(HASH_BITS)) u_hash (
        .clk(clk), .rst(rst), .start_i(start), .da_i(da),
        .rdy_o(hash_rdy), .idx_o(hash_idx)
    );

    daf_ucmatch #(.UC_ENTRIES(UC_ENTRIES)) u_uc (
        .uc_i(uc_tbl), .da_i(da_q), .hit_o(uc_hit)
    );

    assign start = da_valid && !busy_q;
    assign is_bc = &da_q;
    assign is_mc = da_q[0];

    always_comb begin
        if (mode.rx_all || mode.promisc) verdict = 1'b1;
        else if (is_bc)                  verdict = !mode.bcast_dis;
        else if (is_mc)                  verdict = mode.pass_mc ||
                                                   (mode.hash_en && hash_tbl[hash_idx]);
        else                             verdict = uc_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            da_q   <= '0;
            done_q <= 1'b0;
            acc_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                da_q   <= da;
            end else if (hash_rdy) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                acc_q  <= verdict;
            end
        end
    end

    assign filt_done   = done_q;
    assign filt_accept = acc_q;

    a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
        hash_rdy |=> filt_done);

    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        filt_done |=> !filt_done);

    a_r2_override: assert property (@(posedge clk) disable iff (rst)
        (hash_rdy && (mode.promisc || mode.rx_all)) |=> filt_accept);

    a_r3_bcast_block: assert property (@(posedge clk) disable iff (rst)
        (hash_rdy && is_bc && mode.bcast_dis && !mode.promisc && !mode.rx_all)
        |=> !filt_accept);

    a_r6_mc_closed: assert property (@(posedge clk) disable iff (rst)
        (hash_rdy && is_mc && !is_bc && !mode.promisc && !mode.rx_all &&
         !mode.pass_mc && !mode.hash_en) |=> !filt_accept);

endmodule

// File: tb/sim_daf_rx_addr_filter.sv
module sim_daf_rx_addr_filter;

    localparam int HB = 6;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        filt_done;
    logic        filt_accept;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    daf_rx_addr_filter #(.HASH_BITS(HB), .UC_ENTRIES(4)) u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .filt_done(filt_done), .filt_accept(filt_accept)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent index model: serial CRC, invert, reverse, top bits
    function automatic int hidx(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        c = '1;
        for (int b = 0; b < 6; b++)
            for (int t = 0; t < 8; t++) begin
                logic fb;
                fb = c[0] ^ a[8*b+t];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        c = ~c;
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return int'(r >> (32 - HB));
    endfunction

    task automatic wr(input int adr, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 8'(adr); cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clear_cfg();
        wr('h00, 0);
        wr('h10, 0);
        wr('h11, 0);
        for (int e = 0; e < 4; e++) begin
            wr('h40 + 2*e, 0);
            wr('h41 + 2*e, 0);
        end
    endtask

    task automatic run_frame(input logic [47:0] a, input bit exp, input string tag);
        bit early;
        early = 0;
        @(negedge clk);
        da_valid = 1'b1; da = a;
        @(negedge clk);
        da_valid = 1'b0;
        for (int k = 1; k < 7; k++) begin
            @(negedge clk);
            if (filt_done) early = 1;
        end
        @(negedge clk);
        check(!early && filt_done, {tag, " R1 latency"}, filt_done, 1);
        check(filt_accept == exp, tag, filt_accept, exp);
        @(negedge clk);
        check(!filt_done, {tag, " R1 pulse"}, filt_done, 0);
    endtask

    task automatic t_reset();
        check(filt_done == 0, "R1 reset done", filt_done, 0);
        check(filt_accept == 0, "R1 reset accept", filt_accept, 0);
    endtask

    task automatic t_unicast();
        logic [47:0] u;
        u = 48'h5544_3322_1100;
        clear_cfg();
        run_frame(u, 0, "R7 empty table");
        wr('h44, u[31:0]);
        wr('h45, {1'b0, 15'b0, u[47:32]});
        run_frame(u, 0, "R7 disabled entry");
        wr('h45, {1'b1, 15'b0, u[47:32]});
        run_frame(u, 1, "R7 exact match");
        run_frame(u ^ 48'h0100_0000_0000, 0, "R7 one bit off");
        run_frame(u ^ 48'h0000_0000_0002, 0, "R7 low bit off");
    endtask

    task automatic t_broadcast();
        clear_cfg();
        run_frame(BCAST, 1, "R3 bcast default R9");
        wr('h00, 32'h08);
        run_frame(BCAST, 0, "R3 bcast blocked");
        wr('h00, 32'h0A);
        run_frame(BCAST, 0, "R3 block over pass-mc");
        wr('h00, 32'h09);
        run_frame(BCAST, 1, "R2 promisc over R3 block");
    endtask

    task automatic t_passmc();
        clear_cfg();
        run_frame(48'h0000_5E00_0001, 0, "R6 mc closed");
        wr('h00, 32'h02);
        run_frame(48'h0000_5E00_0001, 1, "R4 pass-mc");
        run_frame(48'h1234_5678_9A33, 1, "R4 pass-mc second");
        run_frame(48'h1234_5678_9A32, 0, "R4 unicast unaffected");
    endtask

    task automatic t_hash();
        logic [47:0] lo_a, hi_a, oth;
        int ilo, ihi, ioth;
        clear_cfg();
        lo_a = '0; hi_a = '0;
        for (int k = 0; k < 256; k++) begin
            logic [47:0] c;
            c = 48'h0000_0000_0001 | (48'(k) << 8);
            if (hidx(c) < 32 && lo_a == 0) lo_a = c;
            if (hidx(c) >= 32 && hi_a == 0) hi_a = c;
        end
        ilo = hidx(lo_a); ihi = hidx(hi_a);
        wr('h00, 32'h04);
        wr('h10, 32'(1) << (ilo % 32));
        run_frame(lo_a, 1, "R5 low word hit");
        run_frame(hi_a, 0, "R5 high word clear");
        oth = 48'hA5A5_0000_1101;
        ioth = hidx(oth);
        run_frame(oth, ioth == ilo, "R5 other index");
        wr('h10, 0);
        wr('h11, 32'(1) << (ihi % 32));
        run_frame(hi_a, 1, "R5 high word hit");
        run_frame(lo_a, 0, "R5 low word cleared");
        wr('h00, 32'h00);
        run_frame(hi_a, 0, "R6 hash off");
    endtask

    task automatic t_override();
        clear_cfg();
        wr('h00, 32'h01);
        run_frame(48'h0102_0304_0506, 1, "R2 promisc unicast");
        run_frame(48'h0102_0304_0507, 1, "R2 promisc mc");
        wr('h00, 32'h10);
        run_frame(48'h0102_0304_0506, 1, "R2 rx-all unicast");
        run_frame(48'h0102_0304_0507, 1, "R2 rx-all mc");
    endtask

    task automatic t_busy();
        logic [47:0] u;
        int dones;
        bit first_ok;
        u = 48'h0000_0000_AA00;
        clear_cfg();
        wr('h40, u[31:0]);
        wr('h41, {1'b1, 15'b0, u[47:32]});
        @(negedge clk);
        da_valid = 1'b1; da = u;
        @(negedge clk);
        da = 48'h0000_0000_BB00;
        dones = 0; first_ok = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 3) da_valid = 1'b0;
            if (filt_done) begin
                dones++;
                if (k == 7 && filt_accept) first_ok = 1;
            end
        end
        check(first_ok, "R8 first verdict", first_ok, 1);
        check(dones == 1, "R8 single done", dones, 1);
    endtask

    initial begin
        #(200_000 * 10);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unicast();
        t_broadcast();
        t_passmc();
        t_hash();
        t_override();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule